// File: doc/BRIEF.md
# Window Watchdog with Lead Window

This block supervises a microcontroller through a single active-low trigger input and a single active-low reset output. When reset is released, the controller gets a long lead window in which it has to send its first trigger. Each trigger it accepts then starts a fixed sequence of two windows. The first is a closed window, in which a trigger is treated as a fault. The second is an open window, in which the next trigger is expected. A trigger that comes too early, or no trigger before a window runs out, pulls the reset output low for a fixed pulse. The lead window follows every such pulse.

The windows are counted in ticks of an external oscillator, given as a one-cycle strobe. The reset pulse is counted on a separate fixed time-base strobe. The trigger and receive-line inputs are synchronised to the clock. A trigger counts only after its low level has held for a minimum number of clocks, so short glitches are rejected. A low-power input switches the watchdog off. Once that input is released, the block waits for a falling edge on the receive line and then starts a fresh lead window. A 3-bit phase output shows the current phase.

Top module: `wdog_window`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rst_n_o` is 0 and `phase_o` is 0 (reset pulse).
- R2: The reset pulse lasts exactly PULSE_TICKS `base_tick` strobes. The phase then becomes lead, and `rst_n_o` is 1 in every phase except the reset pulse.
- R3: If no trigger is accepted within LEAD_TICKS `osc_tick` strobes of entering the lead phase, the phase returns to the reset pulse.
- R4: A trigger is accepted only after the synchronised `trig_n` has been high and then low for MINW_CLKS consecutive clocks. A low pulse shorter than that changes nothing.
- R5: An accepted trigger in the lead phase moves the phase to closed on the next clock.
- R6: The closed phase lasts exactly CLOSED_TICKS `osc_tick` strobes when no trigger arrives, then the phase becomes open.
- R7: An accepted trigger in the closed phase moves the phase to the reset pulse on the next clock.
- R8: An accepted trigger in the open phase moves the phase back to closed on the next clock.
- R9: If no trigger is accepted within OPEN_TICKS `osc_tick` strobes of entering the open phase, the phase returns to the reset pulse.
- R10: While `lowpwr` is 1, the phase on the next clock is off, `rst_n_o` is 1 and triggers have no effect.
- R11: After `lowpwr` falls, the phase stays off until a falling edge of the synchronised `rxd`. It then enters the lead phase with a full LEAD_TICKS window. A falling edge of `rxd` in any other phase has no effect.
- R12: The `phase_o` encoding is 0 reset pulse, 1 lead, 2 closed, 3 open, 4 off. No other value appears.
- R13: Triggers during the reset pulse are ignored, and the pulse still ends after PULSE_TICKS `base_tick` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period; counts the window lengths |
| base_tick | input | 1 | One-cycle strobe on the fixed time base; counts the reset pulse |
| trig_n | input | 1 | Active-low trigger from the supervised controller (asynchronous) |
| rxd | input | 1 | Receive-data line; its falling edge re-arms the block after low power (asynchronous) |
| lowpwr | input | 1 | Low-power mode; 1 switches the watchdog off |
| rst_n_o | output | 1 | Active-low reset to the supervised controller |
| phase_o | output | 3 | Current phase (encoding in R12) |

## Verification
The assertions check the following on every cycle:
- `rst_n_o` agrees with the reset-pulse phase.
- The phase code is always legal.
- A filtered trigger in the closed or open phase leads to the required next phase.
- Low power forces the off phase.
- The off phase holds until a receive-line edge.
- The reset pulse can only move on to lead or off.

The exact window lengths in oscillator ticks, the rejection of short glitches at the pin, and the full wake-up sequence depend on chosen stimulus. The bench scenarios cover these. They compare each phase change, and the ticks spent in the phase that ended, against a queue of expected transitions.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [2:0] {
        PH_RESET  = 3'd0,
        PH_LEAD   = 3'd1,
        PH_CLOSED = 3'd2,
        PH_OPEN   = 3'd3,
        PH_OFF    = 3'd4
    } wdw_phase_e;

    typedef struct packed {
        wdw_phase_e phase;
        logic       rst_n;
    } wdw_status_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Counter width able to hold values 0 .. limit-1 (at least one bit)
    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

    // Number of strobes a timed phase lasts
    function automatic int phase_limit(input wdw_phase_e ph, input int lead,
                                       input int closed, input int open_len,
                                       input int pulse);
        case (ph)
            PH_RESET:  return pulse;
            PH_LEAD:   return lead;
            PH_CLOSED: return closed;
            PH_OPEN:   return open_len;
            default:   return 1;
        endcase
    endfunction

    // Which strobe advances the phase counter
    function automatic logic phase_step(input wdw_phase_e ph, input logic osc,
                                        input logic base);
        case (ph)
            PH_RESET:                    return base;
            PH_LEAD, PH_CLOSED, PH_OPEN: return osc;
            default:                     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wdw_sync.sv
module wdw_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= INIT;
                else     stage_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= INIT;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/wdw_trig_filter.sv
module wdw_trig_filter #(
    parameter int MINW_CLKS = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_s,
    output logic trig_ok
);

    localparam int RW = wdw_pkg::cnt_width(MINW_CLKS);
    localparam logic [RW-1:0] RUN_LAST = RW'(MINW_CLKS - 1);

    logic [RW-1:0] run_q;
    logic          armed_q;
    logic          ok_q;

    // A falling edge must follow a high level (armed), and the low level
    // must persist for MINW_CLKS clocks before one accept strobe is issued.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            armed_q <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            ok_q <= 1'b0;
            if (trig_s) begin
                run_q   <= '0;
                armed_q <= 1'b1;
            end else if (armed_q) begin
                if (run_q == RUN_LAST) begin
                    ok_q    <= 1'b1;
                    armed_q <= 1'b0;
                    run_q   <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    assign trig_ok = ok_q;

endmodule

// File: rtl/wdw_phase_ctrl.sv
module wdw_phase_ctrl
    import wdw_pkg::*;
#(
    parameter int LEAD_TICKS   = 7895,
    parameter int CLOSED_TICKS = 1053,
    parameter int OPEN_TICKS   = 1105,
    parameter int PULSE_TICKS  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_tick,
    input  logic        base_tick,
    input  logic        trig_ok,
    input  logic        rx_fall,
    input  logic        lowpwr,
    output wdw_status_t status
);

    localparam int MAXLEN = max2(max2(LEAD_TICKS, CLOSED_TICKS),
                                 max2(OPEN_TICKS, PULSE_TICKS));
    localparam int CW = cnt_width(MAXLEN);

    wdw_phase_e    ph_q, ph_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          rstn_q;
    logic          step;
    logic          expire;
    logic [CW-1:0] last_cnt;

    always_comb begin
        step     = phase_step(ph_q, osc_tick, base_tick);
        last_cnt = CW'(phase_limit(ph_q, LEAD_TICKS, CLOSED_TICKS,
                                   OPEN_TICKS, PULSE_TICKS) - 1);
        expire   = step && (cnt_q == last_cnt);

        ph_d = ph_q;
        case (ph_q)
            PH_RESET: begin
                if (expire) ph_d = PH_LEAD;
            end
            PH_LEAD: begin
                if (trig_ok)     ph_d = PH_CLOSED;
                else if (expire) ph_d = PH_RESET;
            end
            PH_CLOSED: begin
                if (trig_ok)     ph_d = PH_RESET;
                else if (expire) ph_d = PH_OPEN;
            end
            PH_OPEN: begin
                if (trig_ok)     ph_d = PH_CLOSED;
                else if (expire) ph_d = PH_RESET;
            end
            PH_OFF: begin
                if (rx_fall) ph_d = PH_LEAD;
            end
            default: ph_d = PH_RESET;
        endcase
        if (lowpwr) ph_d = PH_OFF;

        if (ph_d != ph_q) cnt_d = '0;
        else if (step)    cnt_d = cnt_q + 1'b1;
        else              cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_RESET;
            cnt_q  <= '0;
            rstn_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            rstn_q <= (ph_d != PH_RESET);
        end
    end

    assign status.phase = ph_q;
    assign status.rst_n = rstn_q;

endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdw_pkg::*;
#(
    parameter int LEAD_TICKS   = 7895,
    parameter int CLOSED_TICKS = 1053,
    parameter int OPEN_TICKS   = 1105,
    parameter int PULSE_TICKS  = 4,
    parameter int MINW_CLKS    = 40,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       base_tick,
    input  logic       trig_n,
    input  logic       rxd,
    input  logic       lowpwr,
    output logic       rst_n_o,
    output logic [2:0] phase_o
);

    logic [1:0]  pins_s;
    logic        trig_s;
    logic        rx_s;
    logic        rx_prev_q;
    logic        rx_fall;
    logic        trig_ok;
    wdw_status_t status;

    wdw_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES),
        .INIT   (2'b11)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({rxd, trig_n}),
        .q_o (pins_s)
    );

    assign trig_s = pins_s[0];
    assign rx_s   = pins_s[1];

    always_ff @(posedge clk) begin
        if (rst) rx_prev_q <= 1'b1;
        else     rx_prev_q <= rx_s;
    end

    assign rx_fall = rx_prev_q && !rx_s;

    wdw_trig_filter #(
        .MINW_CLKS (MINW_CLKS)
    ) u_filter (
        .clk     (clk),
        .rst     (rst),
        .trig_s  (trig_s),
        .trig_ok (trig_ok)
    );

    wdw_phase_ctrl #(
        .LEAD_TICKS   (LEAD_TICKS),
        .CLOSED_TICKS (CLOSED_TICKS),
        .OPEN_TICKS   (OPEN_TICKS),
        .PULSE_TICKS  (PULSE_TICKS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .base_tick (base_tick),
        .trig_ok   (trig_ok),
        .rx_fall   (rx_fall),
        .lowpwr    (lowpwr),
        .status    (status)
    );

    assign rst_n_o = status.rst_n;
    assign phase_o = status.phase;

endmodule

// File: rtl/wdw_checker.sv
module wdw_checker (
    input logic       clk,
    input logic       rst,
    input logic       lowpwr,
    input logic       trig_ok,
    input logic       rx_fall,
    input logic       rst_n_o,
    input logic [2:0] phase_o
);

    // R2 / R1: reset output low exactly in the reset-pulse phase
    p_rstn_matches_phase_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd0) == !rst_n_o);

    // R12: legal phase code
    p_legal_phase_r12: assert property (@(posedge clk) disable iff (rst)
        phase_o <= 3'd4);

    // R7: trigger during closed window forces reset
    p_closed_trig_reset_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd2 && trig_ok && !lowpwr) |=> (phase_o == 3'd0));

    // R8: trigger during open window restarts closed window
    p_open_trig_closed_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd3 && trig_ok && !lowpwr) |=> (phase_o == 3'd2));

    // R5: trigger during lead window starts closed window
    p_lead_trig_closed_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd1 && trig_ok && !lowpwr) |=> (phase_o == 3'd2));

    // R10: low power switches the watchdog off with reset released
    p_lowpwr_off_r10: assert property (@(posedge clk) disable iff (rst)
        lowpwr |=> (phase_o == 3'd4 && rst_n_o));

    // R11: off phase persists until a receive-line falling edge
    p_off_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd4 && !rx_fall) |=> (phase_o == 3'd4));

    // R13: reset pulse only hands over to lead (or off)
    p_reset_exit_r13: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd0 && !lowpwr) |=> (phase_o == 3'd0 || phase_o == 3'd1));

endmodule

bind wdog_window wdw_checker u_wdw_checker (
    .clk     (clk),
    .rst     (rst),
    .lowpwr  (lowpwr),
    .trig_ok (trig_ok),
    .rx_fall (rx_fall),
    .rst_n_o (rst_n_o),
    .phase_o (phase_o)
);

// File: tb/wdog_window_tb_top.sv
module wdog_window_tb_top;
    import wdw_pkg::*;

    localparam int LEAD   = 60;
    localparam int CLOSED = 20;
    localparam int OPENW  = 24;
    localparam int PULSE  = 3;
    localparam int MINW   = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       base_tick = 1'b0;
    logic       trig_n = 1'b1;
    logic       rxd = 1'b1;
    logic       lowpwr = 1'b0;
    logic       rst_n_o;
    logic [2:0] phase_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wdog_window #(
        .LEAD_TICKS   (LEAD),
        .CLOSED_TICKS (CLOSED),
        .OPEN_TICKS   (OPENW),
        .PULSE_TICKS  (PULSE),
        .MINW_CLKS    (MINW)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .base_tick (base_tick),
        .trig_n    (trig_n),
        .rxd       (rxd),
        .lowpwr    (lowpwr),
        .rst_n_o   (rst_n_o),
        .phase_o   (phase_o)
    );

    // Strobe generators, idle while in reset
    initial forever begin
        repeat (9) @(negedge clk);
        if (!rst) osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
    end

    initial forever begin
        repeat (24) @(negedge clk);
        if (!rst) base_tick = 1'b1;
        @(negedge clk);
        base_tick = 1'b0;
    end

    // Running strobe totals as seen by the design at each edge
    int osc_total = 0;
    int base_total = 0;
    always @(posedge clk) begin
        if (osc_tick)  osc_total <= osc_total + 1;
        if (base_tick) base_total <= base_total + 1;
    end

    typedef struct {
        int    ph;
        int    dur;
        bit    chk;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic expect_phase(input int ph, input int dur, input bit chk, input string tag);
        exp_t e;
        e.ph = ph; e.dur = dur; e.chk = chk; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: pops an expected item at every phase change
    int last_ph = 0;
    int snap_osc = 0;
    int snap_base = 0;
    initial forever begin
        @(negedge clk);
        if (rst) begin
            last_ph   = int'(phase_o);
            snap_osc  = osc_total;
            snap_base = base_total;
        end else if (int'(phase_o) != last_ph) begin
            int dur;
            exp_t e;
            dur = (last_ph == int'(PH_RESET)) ? (base_total - snap_base)
                                              : (osc_total - snap_osc);
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected phase change R12", int'(phase_o), last_ph);
            end else begin
                e = exp_q.pop_front();
                check(int'(phase_o) == e.ph, e.tag, int'(phase_o), e.ph);
                if (e.chk) check(dur == e.dur, {e.tag, " duration"}, dur, e.dur);
            end
            check(rst_n_o == (phase_o != 3'd0), "rst_n vs phase R2",
                  int'(rst_n_o), int'(phase_o != 3'd0));
            last_ph   = int'(phase_o);
            snap_osc  = osc_total;
            snap_base = base_total;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    task automatic wait_phase(input int ph, input string tag);
        int n = 0;
        @(negedge clk);
        while (int'(phase_o) != ph && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(int'(phase_o) == ph, {tag, " wait"}, int'(phase_o), ph);
    endtask

    task automatic pulse_trig(input int len);
        @(negedge clk);
        trig_n = 1'b0;
        repeat (len) @(negedge clk);
        trig_n = 1'b1;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(rst_n_o == 1'b0, "R1 reset output", int'(rst_n_o), 0);
        check(phase_o == 3'd0, "R1 reset phase", int'(phase_o), 0);
        expect_phase(int'(PH_LEAD), PULSE, 1'b1, "R2 pulse to lead");
        rst = 1'b0;
        @(negedge clk);
        check(phase_o == 3'd0 && rst_n_o == 1'b0, "R1 first cycle after reset",
              int'(phase_o), 0);
        wait_phase(int'(PH_LEAD), "R2");
        check(rst_n_o == 1'b1, "R2 reset released", int'(rst_n_o), 1);

        // R4: short glitch is ignored
        pulse_trig(3);
        repeat (30) @(negedge clk);
        check(phase_o == 3'd1, "R4 glitch ignored", int'(phase_o), 1);

        // R3 lead expiry, then R13 trigger during pulse ignored
        expect_phase(int'(PH_RESET), LEAD, 1'b1, "R3 lead expiry");
        expect_phase(int'(PH_LEAD), PULSE, 1'b1, "R13 pulse length kept");
        wait_phase(int'(PH_RESET), "R3");
        pulse_trig(20);
        repeat (5) @(negedge clk);
        check(phase_o == 3'd0, "R13 trigger in pulse ignored", int'(phase_o), 0);
        wait_phase(int'(PH_LEAD), "R13");

        // R5 trigger in lead, R6 closed to open
        expect_phase(int'(PH_CLOSED), 0, 1'b0, "R5 lead trigger");
        pulse_trig(20);
        wait_phase(int'(PH_CLOSED), "R5");
        expect_phase(int'(PH_OPEN), CLOSED, 1'b1, "R6 closed length");
        wait_phase(int'(PH_OPEN), "R6");

        // R8 trigger in open restarts closed
        expect_phase(int'(PH_CLOSED), 0, 1'b0, "R8 open trigger");
        pulse_trig(20);
        wait_phase(int'(PH_CLOSED), "R8");
        expect_phase(int'(PH_OPEN), CLOSED, 1'b1, "R6 closed length again");
        wait_phase(int'(PH_OPEN), "R6b");

        // R9 open expiry
        expect_phase(int'(PH_RESET), OPENW, 1'b1, "R9 open expiry");
        expect_phase(int'(PH_LEAD), PULSE, 1'b1, "R2 pulse after open expiry");
        wait_phase(int'(PH_RESET), "R9");
        check(rst_n_o == 1'b0, "R9 reset asserted", int'(rst_n_o), 0);
        wait_phase(int'(PH_LEAD), "R2b");

        // R7 trigger in closed window resets
        expect_phase(int'(PH_CLOSED), 0, 1'b0, "R5 lead trigger again");
        pulse_trig(20);
        wait_phase(int'(PH_CLOSED), "R5b");
        expect_phase(int'(PH_RESET), 0, 1'b0, "R7 early trigger");
        expect_phase(int'(PH_LEAD), PULSE, 1'b1, "R2 pulse after early trigger");
        pulse_trig(20);
        wait_phase(int'(PH_RESET), "R7");
        wait_phase(int'(PH_LEAD), "R2c");

        // R10 low power
        expect_phase(int'(PH_OFF), 0, 1'b0, "R10 low power");
        @(negedge clk);
        lowpwr = 1'b1;
        wait_phase(int'(PH_OFF), "R10");
        check(rst_n_o == 1'b1, "R10 reset released when off", int'(rst_n_o), 1);
        pulse_trig(20);
        repeat (1000) @(negedge clk);
        check(phase_o == 3'd4 && rst_n_o == 1'b1, "R10 off ignores trigger and time",
              int'(phase_o), 4);

        // R11 wake on receive falling edge
        lowpwr = 1'b0;
        repeat (100) @(negedge clk);
        check(phase_o == 3'd4, "R11 off until receive edge", int'(phase_o), 4);
        expect_phase(int'(PH_LEAD), 0, 1'b0, "R11 wake to lead");
        expect_phase(int'(PH_RESET), LEAD, 1'b1, "R11 full lead after wake");
        expect_phase(int'(PH_LEAD), PULSE, 1'b1, "R2 pulse after wake expiry");
        rxd = 1'b0;
        wait_phase(int'(PH_LEAD), "R11");
        rxd = 1'b1;
        wait_phase(int'(PH_RESET), "R11b");
        wait_phase(int'(PH_LEAD), "R2d");

        // R11: receive edge outside off has no effect
        repeat (5) @(negedge clk);
        rxd = 1'b0;
        repeat (10) @(negedge clk);
        rxd = 1'b1;
        repeat (10) @(negedge clk);
        check(phase_o == 3'd1, "R11 receive edge ignored in lead", int'(phase_o), 1);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R12 all expected transitions seen", exp_q.size(), 0);
        done = 1;
        finish_run();
    end

endmodule